// File: doc/BRIEF.md
# Command Data Port

This block sits between a small processor core and one external device that trades single data words with it. It holds an output register that drives the device through `port_out`, and an input path that takes a word from the device on request and passes it to the core. The core's decoder tells the block when a port-write or a port-read instruction starts, with a one-cycle pulse for each. It also signals, cycle by cycle, whether the current cycle is a bus-acknowledge cycle in which the instruction is held while another agent uses the data bus.

A port write does not reach the pins in the same cycle. The word is staged when the instruction starts, and `port_out` changes one cycle later, whether or not bus-acknowledge cycles stretch the instruction. A port read raises the registered strobe `port_rd` for one cycle. The device must present a stable word on `port_in` while the strobe is high. The block captures that word on the clock edge that ends the strobe cycle and hands it to the core with a one-cycle valid pulse. A read that starts while the bus is granted away is held back until the first cycle without bus acknowledge, so the strobe never overlaps a bus-acknowledge stretch.

Top module: `cmd_data_port`

## Requirements
- R1: While `rst_n` is sampled low at a rising edge, the next cycle shows `port_out` = 0, `port_rd` = 0, `rd_valid` = 0 and `rd_data` = 0.
- R2: When `wr_issue` is sampled high with `wr_data` = D at edge k, `port_out` equals D from edge k+2 onward. The state of `bus_ack` has no influence on this timing.
- R3: `port_out` changes only at edge k+2 after a `wr_issue` sampled at edge k. A change of `wr_data` without `wr_issue` leaves `port_out` unchanged.
- R4: A read request is open from the edge that samples `rd_issue` high. At the first edge from then on that samples `bus_ack` low, the request is served: `port_rd` is high for the one following cycle and the request closes.
- R5: After any edge that samples `bus_ack` high, `port_rd` is low for the following cycle.
- R6: At the edge that ends a cycle with `port_rd` high, `port_in` is captured. In the following cycle `rd_data` holds that word and `rd_valid` is high. At all other times `rd_valid` is low.
- R7: `rd_data` keeps its value until the next capture.
- R8: Port-write instructions on consecutive cycles appear on `port_out` in issue order, each for one cycle, the last one remaining.
- R9: A new `rd_issue` that arrives while an earlier request is still held back by `bus_ack` merges with it into a single `port_rd` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_issue | input | 1 | First-cycle pulse of a port-write instruction |
| wr_data | input | W | Word to be written, valid with `wr_issue` |
| rd_issue | input | 1 | First-cycle pulse of a port-read instruction |
| bus_ack | input | 1 | Current cycle is a bus-acknowledge stretch cycle |
| port_in | input | W | Word presented by the external device |
| port_out | output | W | Output port register |
| port_rd | output | 1 | Registered read strobe to the external device |
| rd_data | output | W | Last captured input word, to the core |
| rd_valid | output | 1 | One-cycle pulse marking a fresh `rd_data` |

## Verification
On every cycle the assertions check several properties. A write reaches `port_out` exactly two edges after its issue. `port_out` stays unchanged when no write is in flight. No strobe follows a bus-acknowledge cycle, and an unstretched read strobes on the next cycle. Every strobe is followed by a valid pulse that carries the word the device drove. Other behaviour depends on history and shows only in the bench's scenarios: a read held across several bus-acknowledge cycles and then released, two reads merging into one strobe, write ordering across back-to-back issues, and a reset in the middle of a transfer.

// File: rtl/pdp_pkg.sv
// Package: shared constants and types for the command data port.
// Assumes: nothing beyond IEEE 1800-2017 synthesizable subset.
package pdp_pkg;

    // Default width of the port data path.
    localparam int unsigned PDP_DEF_W = 16;

    // State of a read request waiting for a non-acknowledge cycle.
    typedef enum logic {
        RQ_IDLE = 1'b0,
        RQ_HELD = 1'b1
    } rd_req_e;

endpackage

// File: rtl/pdp_out_stage.sv
// Module: output register path.
// Stages the write word in the instruction's first cycle, then loads the
// pins one cycle later. Assumes wr_issue is a one-cycle pulse per write.
module pdp_out_stage #(
    parameter int unsigned W = pdp_pkg::PDP_DEF_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_issue,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] port_out
);

    logic [W-1:0] stage_q;
    logic         stage_vld_q;

    // Capture the core word and mark it for transfer on the next edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q     <= '0;
            stage_vld_q <= 1'b0;
        end else begin
            stage_vld_q <= wr_issue;
            if (wr_issue) begin
                stage_q <= wr_data;
            end
        end
    end

    // Move the staged word to the pins one cycle after staging.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            port_out <= '0;
        end else if (stage_vld_q) begin
            port_out <= stage_q;
        end
    end

endmodule

// File: rtl/pdp_rd_strobe.sv
// Module: read strobe generator.
// Holds a read request until the first cycle without bus acknowledge, then
// raises a registered one-cycle strobe. Assumes rd_issue marks only the
// first cycle of the read instruction.
module pdp_rd_strobe
    import pdp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rd_issue,
    input  logic bus_ack,
    output logic port_rd
);

    rd_req_e req_q;
    logic    req_open;
    logic    fire;

    // Request is open when newly issued or still held from earlier cycles.
    always_comb begin
        req_open = rd_issue || (req_q == RQ_HELD);
        fire     = req_open && !bus_ack;
    end

    // Track a request that was blocked by a bus-acknowledge cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q <= RQ_IDLE;
        end else if (req_open && bus_ack) begin
            req_q <= RQ_HELD;
        end else begin
            req_q <= RQ_IDLE;
        end
    end

    // Register the strobe so it carries no combinational path to the pins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            port_rd <= 1'b0;
        end else begin
            port_rd <= fire;
        end
    end

endmodule

// File: rtl/pdp_in_capture.sv
// Module: input capture.
// Samples the device bus on the edge that ends a strobe cycle and flags the
// new word for one cycle. Assumes port_in is stable through the strobe cycle.
module pdp_in_capture #(
    parameter int unsigned W = pdp_pkg::PDP_DEF_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         port_rd,
    input  logic [W-1:0] port_in,
    output logic [W-1:0] rd_data,
    output logic         rd_valid
);

    // Latch the device word at the end of the strobe cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (port_rd) begin
            rd_data <= port_in;
        end
    end

    // Pulse valid on the same edge as the capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= port_rd;
        end
    end

endmodule

// File: rtl/cmd_data_port.sv
// Module: command data port top.
// Joins the output register path, the read strobe generator and the input
// capture. Assumes issue pulses come from the instruction decoder, one per
// instruction, and that bus_ack marks stretch cycles of the current one.
module cmd_data_port #(
    parameter int unsigned W = pdp_pkg::PDP_DEF_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_issue,
    input  logic [W-1:0] wr_data,
    input  logic         rd_issue,
    input  logic         bus_ack,
    input  logic [W-1:0] port_in,
    output logic [W-1:0] port_out,
    output logic         port_rd,
    output logic [W-1:0] rd_data,
    output logic         rd_valid
);

    // Output register path.
    pdp_out_stage #(.W(W)) u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_issue (wr_issue),
        .wr_data  (wr_data),
        .port_out (port_out)
    );

    // Read strobe generation.
    pdp_rd_strobe u_strobe (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_issue (rd_issue),
        .bus_ack  (bus_ack),
        .port_rd  (port_rd)
    );

    // Input capture toward the core.
    pdp_in_capture #(.W(W)) u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .port_rd  (port_rd),
        .port_in  (port_in),
        .rd_data  (rd_data),
        .rd_valid (rd_valid)
    );

endmodule

// File: rtl/cmd_data_port_chk.sv
// Module: property checker for the command data port, bound to the top.
// Assumes: synchronous active-low reset; counts cycles since reset so that
// no property looks back past it.
module cmd_data_port_chk #(
    parameter int unsigned W = pdp_pkg::PDP_DEF_W
) (
    input logic         clk,
    input logic         rst_n,
    input logic         wr_issue,
    input logic [W-1:0] wr_data,
    input logic         rd_issue,
    input logic         bus_ack,
    input logic [W-1:0] port_in,
    input logic [W-1:0] port_out,
    input logic         port_rd,
    input logic [W-1:0] rd_data,
    input logic         rd_valid
);

    logic [1:0] since_rst;

    // Saturating count of edges sampled out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_rst <= 2'd0;
        end else if (since_rst != 2'd3) begin
            since_rst <= since_rst + 2'd1;
        end
    end

    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (port_out == '0 && !port_rd && !rd_valid && rd_data == '0));

    a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        wr_issue |-> ##2 (port_out == $past(wr_data, 2)));

    a_r3_out_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 2'd2 && !$past(wr_issue) && !$past(wr_issue, 2))
        |-> $stable(port_out));

    a_r4_strobe_next: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_issue && !bus_ack) |=> port_rd);

    a_r5_no_strobe_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ack |=> !port_rd);

    a_r6_capture: assert property (@(posedge clk) disable iff (!rst_n)
        port_rd |=> (rd_valid && rd_data == $past(port_in)));

    a_r6_valid_only_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 2'd1 && rd_valid) |-> $past(port_rd));

    a_r7_data_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 2'd1 && !rd_valid) |-> $stable(rd_data));

endmodule

bind cmd_data_port cmd_data_port_chk #(.W(W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_issue (wr_issue),
    .wr_data  (wr_data),
    .rd_issue (rd_issue),
    .bus_ack  (bus_ack),
    .port_in  (port_in),
    .port_out (port_out),
    .port_rd  (port_rd),
    .rd_data  (rd_data),
    .rd_valid (rd_valid)
);

// File: tb/cmd_data_port_tb.sv
`timescale 1ns/1ps
// Bench: directed corner cases, then seeded random traffic, compared every
// cycle against a model written from the requirements.
module cmd_data_port_tb;

    localparam int unsigned W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_issue = 1'b0;
    logic [W-1:0] wr_data = '0;
    logic         rd_issue = 1'b0;
    logic         bus_ack = 1'b0;
    logic [W-1:0] port_in = '0;
    logic [W-1:0] port_out;
    logic         port_rd;
    logic [W-1:0] rd_data;
    logic         rd_valid;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc   = 0;

    always #2.5 clk = ~clk;

    cmd_data_port #(.W(W)) u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_issue (wr_issue),
        .wr_data  (wr_data),
        .rd_issue (rd_issue),
        .bus_ack  (bus_ack),
        .port_in  (port_in),
        .port_out (port_out),
        .port_rd  (port_rd),
        .rd_data  (rd_data),
        .rd_valid (rd_valid)
    );

    // Reference model state, derived from the requirements.
    logic [W-1:0] m_stage, m_out, m_data;
    logic         m_stage_v, m_rd, m_held, m_vld;

    function automatic logic strobe_next(logic issue, logic held, logic ack);
        return (issue || held) && !ack;
    endfunction

    function automatic logic held_next(logic issue, logic held, logic ack);
        return (issue || held) && ack;
    endfunction

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (!rst_n) begin
            m_stage <= '0; m_stage_v <= 1'b0; m_out <= '0;
            m_rd <= 1'b0; m_held <= 1'b0; m_vld <= 1'b0; m_data <= '0;
        end else begin
            m_stage_v <= wr_issue;
            if (wr_issue) m_stage <= wr_data;
            if (m_stage_v) m_out <= m_stage;
            m_rd   <= strobe_next(rd_issue, m_held, bus_ack);
            m_held <= held_next(rd_issue, m_held, bus_ack);
            m_vld  <= m_rd;
            if (m_rd) m_data <= port_in;
        end
    end

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // Watchdog: a hung run counts as one failed check.
    always @(posedge clk) begin
        if (cyc > 50000) begin
            n_bad = n_bad + 1;
            $display("FAIL watchdog: cycles %0d expected below %0d", cyc, 50000);
            finish_run();
        end
    end

    task automatic cmp(string req, string what, logic [W-1:0] act, logic [W-1:0] exp);
        n_cmp = n_cmp + 1;
        if (act !== exp) begin
            n_bad = n_bad + 1;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Compare all outputs at the falling edge, then drive the next inputs.
    task automatic step(logic r, logic wi, logic [W-1:0] wd, logic ri, logic ba,
                        logic [W-1:0] pin);
        @(negedge clk);
        cmp("R2", "port_out", port_out, m_out);
        cmp("R4", "port_rd", {{(W-1){1'b0}}, port_rd}, {{(W-1){1'b0}}, m_rd});
        cmp("R6", "rd_valid", {{(W-1){1'b0}}, rd_valid}, {{(W-1){1'b0}}, m_vld});
        cmp("R7", "rd_data", rd_data, m_data);
        rst_n = r; wr_issue = wi; wr_data = wd; rd_issue = ri;
        bus_ack = ba; port_in = pin;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) step(1'b1, 1'b0, W'($urandom), 1'b0, 1'b0, W'($urandom));
    endtask

    initial begin
        void'($urandom(32'h0C0FFEE5));
        // R1: reset state.
        step(1'b0, 1'b0, '0, 1'b0, 1'b0, '0);
        step(1'b0, 1'b0, '0, 1'b0, 1'b0, '0);
        step(1'b1, 1'b0, '0, 1'b0, 1'b0, '0);
        @(negedge clk);
        cmp("R1", "port_out", port_out, '0);
        cmp("R1", "port_rd", {{(W-1){1'b0}}, port_rd}, '0);
        cmp("R1", "rd_valid", {{(W-1){1'b0}}, rd_valid}, '0);
        // R2: plain write, then a write stretched by bus-acknowledge cycles.
        step(1'b1, 1'b1, 16'hA55A, 1'b0, 1'b0, '0);
        idle(3);
        cmp("R2", "port_out plain", port_out, 16'hA55A);
        step(1'b1, 1'b1, 16'h1234, 1'b0, 1'b0, '0);
        step(1'b1, 1'b0, 16'hFFFF, 1'b0, 1'b1, '0);
        step(1'b1, 1'b0, 16'hFFFF, 1'b0, 1'b1, '0);
        // R3: wr_data toggling without an issue is ignored.
        idle(4);
        cmp("R3", "port_out held", port_out, 16'h1234);
        // R8: back-to-back writes.
        step(1'b1, 1'b1, 16'h0001, 1'b0, 1'b0, '0);
        step(1'b1, 1'b1, 16'h0002, 1'b0, 1'b0, '0);
        step(1'b1, 1'b1, 16'h0003, 1'b0, 1'b0, '0);
        idle(3);
        cmp("R8", "port_out last", port_out, 16'h0003);
        // R4 and R6: unstretched read.
        step(1'b1, 1'b0, '0, 1'b1, 1'b0, 16'h0BAD);
        step(1'b1, 1'b0, '0, 1'b0, 1'b0, 16'hBEEF);
        step(1'b1, 1'b0, '0, 1'b0, 1'b0, 16'h0000);
        cmp("R6", "rd_data capture", rd_data, 16'hBEEF);
        // R5: read held over three acknowledge cycles; R9: second issue merges.
        step(1'b1, 1'b0, '0, 1'b1, 1'b1, 16'h1111);
        step(1'b1, 1'b0, '0, 1'b1, 1'b1, 16'h2222);
        step(1'b1, 1'b0, '0, 1'b0, 1'b1, 16'h3333);
        step(1'b1, 1'b0, '0, 1'b0, 1'b0, 16'h4444);
        step(1'b1, 1'b0, '0, 1'b0, 1'b0, 16'h5555);
        idle(3);
        cmp("R9", "rd_data single capture", rd_data, 16'h5555);
        // R1: reset during a held read and pending write.
        step(1'b1, 1'b1, 16'h7777, 1'b1, 1'b1, '0);
        step(1'b0, 1'b0, '0, 1'b0, 1'b0, '0);
        step(1'b1, 1'b0, '0, 1'b0, 1'b0, '0);
        idle(3);
        cmp("R1", "port_out after mid reset", port_out, '0);
        // Seeded random traffic covering R2 to R9.
        for (int i = 0; i < 3000; i++) begin
            step(($urandom % 400) != 0, ($urandom % 4) == 0, W'($urandom),
                 ($urandom % 4) == 0, ($urandom % 3) == 0, W'($urandom));
        end
        idle(4);
        finish_run();
    end

endmodule